// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment base registers and turns a segment choice plus a 16-bit offset into a 20-bit physical address. The selected segment value is moved up by four bit positions, which multiplies it by 16. The offset is then added to that base. Any carry out of the top address bit is dropped, so addresses wrap around inside the 1 MB space.

Software-visible state is limited to the four segment registers. A write port loads one register per cycle. A request port takes a 2-bit segment select and an offset. The physical address comes back with a valid flag exactly one clock after the request. If a write and a request occur in the same cycle, the request uses the register value from before the write.

Every segment therefore starts on a 16-byte boundary and covers at most 64 KB. Segments may overlap, and all four may hold the same base.

Top module: `seg_phys_addr_gen`

## Requirements
- R1: After reset, `addr_valid` is 0, `addr_out` is 0 and all four segment registers hold 0. A request made before any write therefore returns the offset itself.
- R2: For a request with segment value S and offset O, `addr_out` equals (S*16 + O) modulo 2^20.
- R3: Segment value 16'h348A with offset 16'h4214 gives 20'h38AB4.
- R4: A carry out of bit 19 is discarded. Segment 16'hFFFF with offset 16'h0010 gives 20'h00000, and with offset 16'hFFFF it gives 20'h0FFEF.
- R5: The select code 2'b00 picks the extra segment, 2'b01 the code segment, 2'b10 the stack segment and 2'b11 the data segment. The write port and the request port use the same encoding, and a write changes only the register it selects.
- R6: When a write and a request fall in the same cycle, the request uses the old register value. The new value applies from the next cycle on.
- R7: `addr_valid` is 1 in the cycle after a cycle with `req_valid` high, and 0 otherwise. Back-to-back requests give back-to-back results.
- R8: While `addr_valid` is 0, `addr_out` keeps the last address produced.
- R9: If all four registers hold the same base, every select gives the same address for a given offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Load the segment register chosen by `wr_sel` |
| wr_sel | input | 2 | Segment register to write (encoding as in R5) |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | An address request is present this cycle |
| req_sel | input | 2 | Segment used by the request (encoding as in R5) |
| req_offset | input | 16 | Offset added to the segment base |
| addr_valid | output | 1 | `addr_out` holds a new result this cycle |
| addr_out | output | 20 | Physical address |

## Verification
The checker keeps its own copy of the four segment values, built only from activity on the write port. It therefore assumes that a write with `wr_en` high always carries a defined select and data, and that `req_sel` and `req_offset` are defined whenever `req_valid` is high. The bench always drives every input to a known value on the falling edge, with reset held low first. It issues writes and requests only after reset is released, including cycles that combine a write and a request to the same register.

// File: rtl/seg_addr_pkg.sv
// Package: shared sizes and the segment select encoding for the
// physical address generator.
// Assumes: exactly four segments, so the select is two bits wide.
package seg_addr_pkg;

    localparam int SEG_W      = 16;
    localparam int OFF_W      = 16;
    localparam int BASE_SHIFT = 4;
    localparam int PA_W       = SEG_W + BASE_SHIFT;
    localparam int NUM_SEG    = 4;
    localparam int SEL_W      = $clog2(NUM_SEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_sel_e;

endpackage

// File: rtl/seg_regfile.sv
// Module: seg_regfile
// Holds NUM_SEG segment base registers with one write port and one
// combinational read port.
// Assumes: a read in the same cycle as a write returns the old value,
// because the register updates only at the clock edge.
module seg_regfile #(
    parameter int SEG_W   = 16,
    parameter int NUM_SEG = 4,
    parameter int SEL_W   = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_data
);

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;

    genvar g;
    generate
        for (g = 0; g < NUM_SEG; g++) begin : g_seg
            // Purpose: clear on reset, load when this entry is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    seg_q[g] <= '0;
                end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                    seg_q[g] <= wr_data;
                end
            end
        end
    endgenerate

    // Purpose: select the requested entry for the adder.
    always_comb begin
        rd_data = seg_q[rd_sel];
    end

endmodule

// File: rtl/seg_base_adder.sv
// Module: seg_base_adder
// Shifts a segment value left by SHIFT bits and adds a zero-extended
// offset. The sum is truncated to the address width, so it wraps.
// Assumes: OFF_W does not exceed SEG_W + SHIFT.
module seg_base_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  phys
);

    logic [PA_W-1:0] base_w;
    logic [PA_W-1:0] off_ext;

    // Purpose: form the aligned base, extend the offset, and add modulo 2^PA_W.
    always_comb begin
        base_w  = {seg_val, {SHIFT{1'b0}}};
        off_ext = PA_W'(offset);
        phys    = base_w + off_ext;
    end

endmodule

// File: rtl/seg_addr_outreg.sv
// Module: seg_addr_outreg
// Registers the computed address and its valid flag. The address is
// held while no new result arrives.
// Assumes: in_addr is meaningful only while in_valid is high.
module seg_addr_outreg #(
    parameter int PA_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [PA_W-1:0] in_addr,
    output logic            out_valid,
    output logic [PA_W-1:0] out_addr
);

    // Purpose: mark a result present exactly one cycle after a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Purpose: capture the address on a request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
        end else if (in_valid) begin
            out_addr <= in_addr;
        end
    end

endmodule

// File: rtl/seg_phys_addr_gen.sv
// Module: seg_phys_addr_gen (top)
// Segment register file, base shift-and-add, and registered output.
// The result appears one cycle after the request.
// Assumes: a write and a request in one cycle see the old register value.
module seg_phys_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W   = seg_addr_pkg::SEG_W,
    parameter int OFF_W   = seg_addr_pkg::OFF_W,
    parameter int SHIFT   = seg_addr_pkg::BASE_SHIFT,
    parameter int NUM_SEG = seg_addr_pkg::NUM_SEG
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NUM_SEG)-1:0] wr_sel,
    input  logic [SEG_W-1:0]           wr_data,
    input  logic                       req_valid,
    input  logic [$clog2(NUM_SEG)-1:0] req_sel,
    input  logic [OFF_W-1:0]           req_offset,
    output logic                       addr_valid,
    output logic [SEG_W+SHIFT-1:0]     addr_out
);

    localparam int SEL_W = $clog2(NUM_SEG);
    localparam int AW    = SEG_W + SHIFT;

    logic [SEG_W-1:0] seg_rd;
    logic [AW-1:0]    phys_c;

    seg_regfile #(
        .SEG_W   (SEG_W),
        .NUM_SEG (NUM_SEG),
        .SEL_W   (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (req_sel),
        .rd_data (seg_rd)
    );

    seg_base_adder #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT),
        .PA_W  (AW)
    ) u_add (
        .seg_val (seg_rd),
        .offset  (req_offset),
        .phys    (phys_c)
    );

    seg_addr_outreg #(
        .PA_W (AW)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_addr   (phys_c),
        .out_valid (addr_valid),
        .out_addr  (addr_out)
    );

endmodule

// File: rtl/seg_phys_addr_chk.sv
// Module: seg_phys_addr_chk
// Assertion checker bound to seg_phys_addr_gen. It keeps a shadow copy
// of the segment registers, built from the write port alone.
// Assumes: inputs are defined whenever their enable is high.
module seg_phys_addr_chk #(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int NUM_SEG = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [$clog2(NUM_SEG)-1:0] wr_sel,
    input logic [SEG_W-1:0]           wr_data,
    input logic                       req_valid,
    input logic [$clog2(NUM_SEG)-1:0] req_sel,
    input logic [OFF_W-1:0]           req_offset,
    input logic                       addr_valid,
    input logic [SEG_W+SHIFT-1:0]     addr_out
);

    localparam int AW = SEG_W + SHIFT;

    logic [NUM_SEG-1:0][SEG_W-1:0] shadow;
    logic [AW-1:0]                 exp_q;
    logic                          seen_edge;

    // Purpose: mirror segment writes seen at the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            shadow[wr_sel] <= wr_data;
        end
    end

    // Purpose: expected address from pre-write shadow values (R2, R6).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else if (req_valid) begin
            exp_q <= AW'({shadow[req_sel], {SHIFT{1'b0}}} + AW'(req_offset));
        end
    end

    // Purpose: note that at least one clock edge has passed.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    a_r2_sum_matches_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> addr_out == exp_q);

    a_r2_low_nibble_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_out[SHIFT-1:0] == $past(req_offset[SHIFT-1:0]));

    a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);

    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(addr_out));

    // R1: outputs are cleared while reset is applied.
    always_ff @(posedge clk) begin
        if (seen_edge && !$past(rst_n)) begin
            a_r1_reset_clears: assert (!addr_valid && addr_out == '0);
        end
    end

endmodule

bind seg_phys_addr_gen seg_phys_addr_chk #(
    .SEG_W   (SEG_W),
    .OFF_W   (OFF_W),
    .SHIFT   (SHIFT),
    .NUM_SEG (NUM_SEG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .req_valid  (req_valid),
    .req_sel    (req_sel),
    .req_offset (req_offset),
    .addr_valid (addr_valid),
    .addr_out   (addr_out)
);

// File: tb/seg_phys_addr_gen_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected addresses and the monitor
// pops them when results appear.
module seg_phys_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [1:0]  req_sel;
    logic [15:0] req_offset;
    logic        addr_valid;
    logic [19:0] addr_out;

    typedef struct {
        logic [19:0] addr;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] model_seg [4];
    logic [19:0] last_addr;
    int          cyc_cnt = 0;
    int          checks  = 0;
    int          errors  = 0;
    bit          mon_on  = 1'b0;
    bit          done    = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    seg_phys_addr_gen u_seg_phys_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .req_valid  (req_valid),
        .req_sel    (req_sel),
        .req_offset (req_offset),
        .addr_valid (addr_valid),
        .addr_out   (addr_out)
    );

    function automatic logic [19:0] calc(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] full;
        full = {1'b0, s, 4'h0} + {5'h0, o};
        return full[19:0];
    endfunction

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle of stimulus. A literal expectation overrides the model when use_lit is set.
    task automatic step(input bit we, input logic [1:0] ws, input logic [15:0] wd,
                        input bit rv, input logic [1:0] rs, input logic [15:0] ro,
                        input string tag, input bit use_lit = 0,
                        input logic [19:0] lit = '0);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_data = wd;
        req_valid = rv; req_sel = rs; req_offset = ro;
        if (rv) begin
            e.addr = use_lit ? lit : calc(model_seg[rs], ro);
            e.cyc  = cyc_cnt + 1;
            e.tag  = tag;
            sb_q.push_back(e);
        end
        if (we) model_seg[ws] = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "idle");
    endtask

    // Monitor: compare results with the scoreboard, and check holding when idle.
    always @(negedge clk) begin
        if (mon_on) begin
            if (addr_valid) begin
                if (sb_q.size() == 0) begin
                    errors++; checks++;
                    $display("FAIL R7: addr_valid without request, got %h expected none", addr_out);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({e.tag, " R7 latency"}, 20'(cyc_cnt), 20'(e.cyc));
                    check(e.tag, addr_out, e.addr);
                    last_addr = addr_out;
                end
            end else begin
                check("R8 hold", addr_out, last_addr);
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model_seg[i] = '0;
        rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0;
        req_valid = 0; req_sel = 0; req_offset = 0;
        last_addr = '0;
        repeat (4) @(negedge clk);
        check("R1 reset valid", {19'h0, addr_valid}, 20'h0);
        check("R1 reset addr", addr_out, 20'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: registers are zero, so the result equals the offset.
        for (int s = 0; s < 4; s++) step(0, 0, 0, 1, 2'(s), 16'h1234, "R1 zero seg", 1, 20'h01234);

        // R5: distinct values per select code.
        step(1, 2'b00, 16'h1000, 0, 0, 0, "wr");
        step(1, 2'b01, 16'h2000, 0, 0, 0, "wr");
        step(1, 2'b10, 16'h3000, 0, 0, 0, "wr");
        step(1, 2'b11, 16'h4000, 0, 0, 0, "wr");
        step(0, 0, 0, 1, 2'b00, 16'h0005, "R5 extra", 1, 20'h10005);
        step(0, 0, 0, 1, 2'b01, 16'h0005, "R5 code",  1, 20'h20005);
        step(0, 0, 0, 1, 2'b10, 16'h0005, "R5 stack", 1, 20'h30005);
        step(0, 0, 0, 1, 2'b11, 16'h0005, "R5 data",  1, 20'h40005);
        idle(2);

        // R3: worked example.
        step(1, 2'b01, 16'h348A, 0, 0, 0, "wr");
        step(0, 0, 0, 1, 2'b01, 16'h4214, "R3 example", 1, 20'h38AB4);
        step(0, 0, 0, 1, 2'b00, 16'h0000, "R5 extra untouched", 1, 20'h10000);

        // R4: wraparound.
        step(1, 2'b10, 16'hFFFF, 0, 0, 0, "wr");
        step(0, 0, 0, 1, 2'b10, 16'h0010, "R4 wrap zero", 1, 20'h00000);
        step(0, 0, 0, 1, 2'b10, 16'hFFFF, "R4 wrap max",  1, 20'h0FFEF);
        idle(3);

        // R6: write and request in the same cycle.
        step(1, 2'b11, 16'hABCD, 1, 2'b11, 16'h0000, "R6 old value", 1, 20'h40000);
        step(0, 0, 0, 1, 2'b11, 16'h0000, "R6 new value", 1, 20'hABCD0);

        // R9: all four overlap.
        for (int s = 0; s < 4; s++) step(1, 2'(s), 16'h0100, 0, 0, 0, "wr");
        for (int s = 0; s < 4; s++) step(0, 0, 0, 1, 2'(s), 16'h0020, "R9 overlap", 1, 20'h01020);
        idle(2);

        // R2: varied writes and requests with gaps, against the model.
        for (int i = 0; i < 40; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h3A7B + 16'h1F3);
            step(i % 3 == 0, 2'(i), v ^ 16'h5555, i % 4 != 3, 2'(i * 7 + 1), 16'(v * 16'h0013), "R2 sweep");
        end
        idle(3);

        done = 1'b1;
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R7: pending results got %0d expected 0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule